// File: doc/BRIEF.md
# Synchronous Sample-Start Trigger

This block lets several independent recording modules take their samples in lockstep. The block does not time samples from its own clock. A single master drives a sample-start pulse, at the nominal sample rate, into a general-purpose input on every module. Each module turns every valid pulse into a one-clock start strobe for its local acquisition sequencer. Because every sample starts on the shared pulse, modules stay aligned even when their local oscillators drift. The worst-case alignment error is a few local clock periods, which is far below one sample period.

Control software first arms the block. The block then waits for the first valid pulse, enters the running state and emits a strobe for that pulse and for every valid pulse after it. It does this until it is halted. The incoming pulse is asynchronous. It is resynchronised and then qualified against a programmable minimum width to reject glitches. While running, a programmable watchdog window sets a sticky missed-pulse flag when the pulse train stops; the block keeps waiting. A halt waits for any sample in flight to finish. The block then returns to idle and must be armed again.

Top module: `smp_sync_trig`

## Requirements
- R1: While reset is active, and on the first cycle after it, `start_stb`, `armed`, `running` and `missed` are all 0.
- R2: In idle, pulses on `ext_pulse` produce no strobe. A one-cycle `arm_req` makes `armed` read 1 on the next cycle and clears `missed` to 0.
- R3: A pulse that stays high for fewer than `min_width` consecutive clock cycles produces no strobe and leaves the state unchanged. A `min_width` of 0 is treated as 1.
- R4: An accepted pulse produces exactly one `start_stb`, one cycle wide. If the pulse is first sampled high at clock edge E1, `start_stb` is high in the cycle after edge E(2+`min_width`).
- R5: While armed, the first accepted pulse moves the block to running (`armed` 0, `running` 1) and is itself strobed.
- R6: While running with no halt pending, every accepted pulse produces one strobe, and `start_stb` is only ever high while `running` is 1.
- R7: While running, if no pulse is accepted for `miss_limit` cycles, `missed` becomes 1. It stays 1 until the next arm. `running` stays 1 and later pulses are still strobed.
- R8: A halt while `smp_busy` is 1 is held pending. Pulses produce no strobe while the halt is pending. The block leaves running on the edge after `smp_busy` is seen low.
- R9: A halt with `smp_busy` low makes the block idle on the next cycle, whether it was armed or running.
- R10: `armed` and `running` are never 1 together. After a halt, pulses are ignored until the block is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_pulse | input | 1 | Asynchronous shared sample-start pulse |
| arm_req | input | 1 | One-cycle arm command |
| halt_req | input | 1 | One-cycle halt command |
| smp_busy | input | 1 | High while the sequencer is inside a sample |
| min_width | input | MW_W | Minimum accepted pulse width in cycles |
| miss_limit | input | TO_W | Watchdog window in cycles |
| start_stb | output | 1 | One-cycle sample-start strobe |
| armed | output | 1 | Waiting for the first pulse |
| running | output | 1 | Acquiring one sample per pulse |
| missed | output | 1 | Sticky: the pulse train stopped while running |

## Verification
The properties assume that `arm_req` and `halt_req` are one-cycle commands that do not overlap. They also assume that `min_width` and `miss_limit` stay constant while the block is armed or running, and that pulses are spaced further apart than the synchroniser latency. The stimulus changes inputs only on falling edges. It holds the configuration fixed for the whole run, with a minimum width of 3 and a window of 40 cycles. It spaces pulses 25 cycles apart, except where a longer gap is wanted to trip the watchdog.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } sst_state_e;
endpackage

// File: rtl/sst_rst_sync.sv
module sst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/sst_sync.sv
module sst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sst_pulse_qual.sv
module sst_pulse_qual #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl,
  input  logic [CW-1:0] min_width,
  output logic          qual
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] min_eff;
  logic          cnt_en;

  assign min_eff = (min_width == '0) ? {{(CW-1){1'b0}}, 1'b1} : min_width;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (!lvl)                 cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    else                       cnt_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign qual = lvl && (cnt_q == (min_eff - 1'b1));
endmodule

// File: rtl/sst_watchdog.sv
module sst_watchdog #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          kick,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

  logic [TW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] lim_eff;
  logic          cnt_en;

  assign lim_eff = (limit == '0) ? {{(TW-1){1'b0}}, 1'b1} : limit;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (!run_en || kick)       cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    else                       cnt_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = run_en && !kick && (cnt_q >= (lim_eff - 1'b1));
endmodule

// File: rtl/sst_ctrl.sv
module sst_ctrl
  import sst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_req,
  input  logic       halt_req,
  input  logic       smp_busy,
  input  logic       qual,
  input  logic       expire,
  output sst_state_e state,
  output logic       stb,
  output logic       missed
);
  sst_state_e st_q, st_d;
  logic       hp_q, hp_d;
  logic       stb_q, stb_d;
  logic       miss_q, miss_d;

  always_comb begin
    st_d   = st_q;
    hp_d   = hp_q;
    stb_d  = 1'b0;
    miss_d = miss_q;
    unique case (st_q)
      ST_IDLE: begin
        if (arm_req) begin
          st_d   = ST_ARMED;
          miss_d = 1'b0;
          hp_d   = 1'b0;
        end
      end
      ST_ARMED: begin
        if (halt_req) begin
          st_d = ST_IDLE;
        end else if (qual) begin
          st_d  = ST_RUN;
          stb_d = 1'b1;
        end
      end
      ST_RUN: begin
        if (expire) miss_d = 1'b1;
        if (halt_req || hp_q) begin
          if (!smp_busy) begin
            st_d = ST_IDLE;
            hp_d = 1'b0;
          end else begin
            hp_d = 1'b1;
          end
        end else if (qual) begin
          stb_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hp_q   <= 1'b0;
      stb_q  <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      hp_q   <= hp_d;
      stb_q  <= stb_d;
      miss_q <= miss_d;
    end
  end

  assign state  = st_q;
  assign stb    = stb_q;
  assign missed = miss_q;
endmodule

// File: rtl/smp_sync_trig.sv
module smp_sync_trig
  import sst_pkg::*;
#(
  parameter int MW_W      = 8,
  parameter int TO_W      = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_pulse,
  input  logic            arm_req,
  input  logic            halt_req,
  input  logic            smp_busy,
  input  logic [MW_W-1:0] min_width,
  input  logic [TO_W-1:0] miss_limit,
  output logic            start_stb,
  output logic            armed,
  output logic            running,
  output logic            missed
);
  logic       rst_n_s;
  logic       pulse_lvl;
  logic       pulse_ok;
  logic       wd_expire;
  sst_state_e state;

  sst_rst_sync #(.STAGES(SYNC_STGS)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n_o(rst_n_s)
  );

  sst_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n_s),
    .d    (ext_pulse),
    .q    (pulse_lvl)
  );

  sst_pulse_qual #(.CW(MW_W)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .lvl      (pulse_lvl),
    .min_width(min_width),
    .qual     (pulse_ok)
  );

  sst_watchdog #(.TW(TO_W)) u_wd (
    .clk   (clk),
    .rst_n (rst_n_s),
    .run_en(state == ST_RUN),
    .kick  (pulse_ok),
    .limit (miss_limit),
    .expire(wd_expire)
  );

  sst_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .arm_req (arm_req),
    .halt_req(halt_req),
    .smp_busy(smp_busy),
    .qual    (pulse_ok),
    .expire  (wd_expire),
    .state   (state),
    .stb     (start_stb),
    .missed  (missed)
  );

  assign armed   = (state == ST_ARMED);
  assign running = (state == ST_RUN);
endmodule

// File: rtl/smp_sync_trig_chk.sv
module smp_sync_trig_chk (
  input logic clk,
  input logic rst_n,
  input logic arm_req,
  input logic halt_req,
  input logic smp_busy,
  input logic start_stb,
  input logic armed,
  input logic running,
  input logic missed
);
  // R10
  both_states_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed && running));

  // R2
  arm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !running && arm_req) |=> armed);

  // R2
  missed_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(missed) |-> $past(arm_req));

  // R7
  missed_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(missed) |-> running);

  // R4
  stb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |=> !start_stb);

  // R6
  stb_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |-> running);

  // R9
  halt_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && halt_req && !smp_busy) |=> !running);

  // R9
  halt_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && halt_req) |=> (!armed && !running));

  // R10
  idle_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !running) |=> !start_stb);
endmodule

bind smp_sync_trig smp_sync_trig_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .arm_req  (arm_req),
  .halt_req (halt_req),
  .smp_busy (smp_busy),
  .start_stb(start_stb),
  .armed    (armed),
  .running  (running),
  .missed   (missed)
);

// File: tb/smp_sync_trig_tb_top.sv
module smp_sync_trig_tb_top;
  localparam int MW_W  = 8;
  localparam int TO_W  = 16;
  localparam int MINW  = 3;
  localparam int LIMIT = 40;
  localparam int PER   = 25;

  logic clk;
  logic rst_n;
  logic ext_pulse, arm_req, halt_req, smp_busy;
  logic start_stb, armed, running, missed;

  int n_chk;
  int n_fail;
  int cyc;
  int exp_q[$];
  bit done;

  smp_sync_trig #(.MW_W(MW_W), .TO_W(TO_W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_pulse (ext_pulse),
    .arm_req   (arm_req),
    .halt_req  (halt_req),
    .smp_busy  (smp_busy),
    .min_width (MW_W'(MINW)),
    .miss_limit(TO_W'(LIMIT)),
    .start_stb (start_stb),
    .armed     (armed),
    .running   (running),
    .missed    (missed)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // monitor: pops the expected strobe cycle for every strobe seen
  always @(negedge clk) begin
    if (rst_n && start_stb) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2/R3/R8/R10 unexpected strobe", 1, 0);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(cyc == e, "R4 strobe cycle", cyc, e);
      end
    end
  end

  // driver: one pulse of w cycles, then idle for gap cycles
  task automatic pulse(input int w, input bit accept, input int gap);
    @(negedge clk);
    if (accept) exp_q.push_back(cyc + 2 + MINW);
    ext_pulse = 1'b1;
    repeat (w) @(negedge clk);
    ext_pulse = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic cmd_arm();
    @(negedge clk); arm_req = 1'b1;
    @(negedge clk); arm_req = 1'b0;
  endtask

  task automatic cmd_halt();
    @(negedge clk); halt_req = 1'b1;
    @(negedge clk); halt_req = 1'b0;
  endtask

  task automatic drained(input string req);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      finish_run();
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; done = 1'b0;
    rst_n = 1'b0; ext_pulse = 1'b0; arm_req = 1'b0; halt_req = 1'b0; smp_busy = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet while reset is active
    check({start_stb, armed, running, missed} == 4'b0, "R1 in reset",
          int'({start_stb, armed, running, missed}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check({start_stb, armed, running, missed} == 4'b0, "R1 after reset",
          int'({start_stb, armed, running, missed}), 0);

    // R2: pulse in idle ignored
    pulse(4, 1'b0, 12);
    drained("R2 idle pulse");
    check(!running && !armed, "R2 idle stays idle", int'(running), 0);

    cmd_arm();
    check(armed && !running, "R2 armed after arm", int'(armed), 1);

    // R3: narrow pulse rejected
    pulse(2, 1'b0, 12);
    check(armed && !running, "R3 narrow pulse keeps armed", int'(armed), 1);

    // R5: first accepted pulse (exactly min width) starts running
    pulse(MINW, 1'b1, PER - MINW);
    check(running && !armed, "R5 running after first pulse", int'(running), 1);
    drained("R5 first strobe");

    // R6: periodic pulses, one strobe each
    for (int i = 0; i < 4; i++) pulse(4, 1'b1, PER - 4);
    drained("R6 periodic strobes");
    check(!missed, "R6 no miss with steady pulses", int'(missed), 0);

    // R3 while running: glitch gives no strobe
    pulse(1, 1'b0, PER - 1);
    drained("R3 glitch while running");

    // R7: long gap sets missed, keeps running
    repeat (60) @(negedge clk);
    check(missed, "R7 missed set", int'(missed), 1);
    check(running, "R7 still running", int'(running), 1);
    pulse(4, 1'b1, PER - 4);
    drained("R7 strobe after miss");
    check(missed, "R7 missed sticky", int'(missed), 1);

    // R8: halt while busy is pending, pulses suppressed
    smp_busy = 1'b1;
    cmd_halt();
    pulse(4, 1'b0, PER - 4);
    check(running, "R8 pending halt keeps running", int'(running), 1);
    smp_busy = 1'b0;
    @(negedge clk);
    check(!running && !armed, "R8 idle after busy drops", int'(running), 0);

    // R10: pulse after halt ignored until re-armed
    pulse(4, 1'b0, PER - 4);
    drained("R10 pulse after halt");
    check(!running && !armed, "R10 stays idle", int'(running), 0);

    // R2: arm clears missed
    cmd_arm();
    check(armed && !missed, "R2 arm clears missed", int'(missed), 0);

    // R9: halt while armed
    cmd_halt();
    check(!armed && !running, "R9 halt from armed", int'(armed), 0);

    // R9: halt while running with busy low
    cmd_arm();
    pulse(5, 1'b1, PER - 5);
    check(running, "R9 running before halt", int'(running), 1);
    cmd_halt();
    check(!running && !armed, "R9 halt from running", int'(running), 0);
    drained("R9 final queue");

    repeat (10) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule